// File: doc/BRIEF.md
# Digital Component Video Timing-Code Decoder

This block sits at the receiving end of a 4:2:2 component digital video stream that carries one sample per clock, either 8 or 10 bits wide. It watches the sample stream for the reserved preamble that introduces an embedded timing word. It decodes the field, vertical-blank and horizontal-blank flags from that word and checks the word's four protection bits. It also marks the two timing words that open a field.

Between a start-of-active-video word and the next reserved all-ones sample, the block takes the interleaved chroma and luma samples. It rebuilds them into whole pixels, each with a luma value and the chroma pair it shares with its neighbour, and qualifies each pixel with a one-cycle valid strobe. Downstream logic uses the flags for raster position, the field-start pulses for frame alignment, and the pixel strobe to write a line buffer or feed a colour converter.

Top module: `vtd_trs_decoder`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, every output is 0.
- R2: A sample is treated as a timing word only when the three samples before it were all-ones, all-zeros and all-zeros at the full sample width. The 8-bit timing code is the top 8 bits of that sample. In the same code sequence without the all-ones sample, nothing is decoded.
- R3: Timing code layout: bit 7 is 1, bit 6 is F, bit 5 is V, bit 4 is H, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V, bit 0 = F^V^H. On a good code, `fld_o`, `vblk_o` and `hblk_o` show F, V and H from the cycle after the code sample.
- R4: A code with bit 7 clear or any protection bit wrong makes `code_err_o` high for exactly one cycle, and leaves the three flags unchanged.
- R5: Until the first good code arrives, the flags stay 0, `code_err_o` never rises and no pixel is produced.
- R6: Code 8'h80 pulses `even_sof_o` for one cycle. Code 8'hC7 pulses `odd_sof_o` for one cycle.
- R7: After a good code with V=0 and H=0, the samples are taken in the order Cb, Y0, Cr, Y1. One cycle after Cr, the output is the pixel (Y0, Cb, Cr) with `pix_vld_o` high. One cycle after Y1, the output is (Y1, Cb, Cr) with `pix_vld_o` high.
- R8: Every good start-of-active-video code restarts the sample order at Cb, whatever phase the previous line stopped in.
- R9: No pixel is produced after an all-ones sample, after a code with V or H set, or on a line opened by a code with V=1.
- R10: `pix_vld_o` is high only for rebuilt pixels. `luma_o`, `cb_o` and `cr_o` keep their last values while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_i | input | W | Incoming video sample |
| fld_o | output | 1 | Field flag of the last good code |
| vblk_o | output | 1 | Vertical-blank flag of the last good code |
| hblk_o | output | 1 | Horizontal flag of the last good code |
| code_err_o | output | 1 | One-cycle pulse on a bad timing code |
| even_sof_o | output | 1 | One-cycle pulse on code 8'h80 |
| odd_sof_o | output | 1 | One-cycle pulse on code 8'hC7 |
| luma_o | output | W | Luma of the current pixel |
| cb_o | output | W | Blue-difference chroma of the current pixel |
| cr_o | output | W | Red-difference chroma of the current pixel |
| pix_vld_o | output | 1 | One-cycle strobe per rebuilt pixel |

## Verification
A wrong sample-history register shows up within four samples of the next preamble. A code is then missed or invented, so the flags and field-start pulses differ from the model right after the code. A wrong sample-phase or active state shows up within a single pixel pair: the strobe fires on the wrong cycle, or luma and chroma come out swapped. A stale lock or flag bit is exposed by the next corrupted code, which must pulse the error output while all three flags stay where they were.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } vtd_flags_t;

   typedef enum logic [1:0] {
      PH_CB = 2'd0,
      PH_Y0 = 2'd1,
      PH_CR = 2'd2,
      PH_Y1 = 2'd3
   } vtd_phase_t;

   localparam int unsigned CODE_W   = 8;
   localparam int unsigned PRE_LEN  = 3;
   localparam logic [CODE_W-1:0] CODE_EVEN = 8'h80;
   localparam logic [CODE_W-1:0] CODE_ODD  = 8'hC7;

   function automatic logic vtd_code_ok(input logic [CODE_W-1:0] c);
      logic f, v, h;
      f = c[6];
      v = c[5];
      h = c[4];
      return c[7] && (c[3] == (v ^ h)) && (c[2] == (f ^ h))
             && (c[1] == (f ^ v)) && (c[0] == (f ^ v ^ h));
   endfunction

endpackage

// File: rtl/vtd_preamble.sv
module vtd_preamble #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] smp_i,
   output logic         code_hit_o,
   output logic         ones_o
);
   import vtd_pkg::*;

   localparam int unsigned HIST = PRE_LEN;
   localparam logic [W-1:0] ALL_ONES  = '1;
   localparam logic [W-1:0] ALL_ZEROS = '0;

   logic [W-1:0] hist_q [HIST];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < HIST; i++) hist_q[i] <= ALL_ZEROS;
      end else begin
         hist_q[0] <= smp_i;
         for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
      end
   end

   logic [HIST-1:0] match;
   genvar g;
   generate
      for (g = 0; g < HIST; g++) begin : g_match
         if (g == HIST - 1) begin : g_lead
            assign match[g] = (hist_q[g] == ALL_ONES);
         end else begin : g_zero
            assign match[g] = (hist_q[g] == ALL_ZEROS);
         end
      end
   endgenerate

   assign code_hit_o = &match;
   assign ones_o     = (smp_i == ALL_ONES);

endmodule

// File: rtl/vtd_code_check.sv
module vtd_code_check #(
   parameter int unsigned W = 8
) (
   input  logic                          [W-1:0] smp_i,
   output logic                                  good_o,
   output vtd_pkg::vtd_flags_t                   flags_o,
   output logic                                  is_even_o,
   output logic                                  is_odd_o
);
   import vtd_pkg::*;

   localparam int unsigned DROP = W - CODE_W;

   logic [CODE_W-1:0] code;

   generate
      if (DROP == 0) begin : g_exact
         assign code = smp_i;
      end else begin : g_wide
         logic [DROP-1:0] unused_lsb;
         assign code       = smp_i[W-1 -: CODE_W];
         assign unused_lsb = smp_i[DROP-1:0];
      end
   endgenerate

   assign good_o    = vtd_code_ok(code);
   assign flags_o   = '{f: code[6], v: code[5], h: code[4]};
   assign is_even_o = (code == CODE_EVEN);
   assign is_odd_o  = (code == CODE_ODD);

endmodule

// File: rtl/vtd_pixel_pair.sv
module vtd_pixel_pair #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic         take_i,
   input  logic [W-1:0] smp_i,
   output logic [W-1:0] luma_o,
   output logic [W-1:0] cb_o,
   output logic [W-1:0] cr_o,
   output logic         vld_o
);
   import vtd_pkg::*;

   vtd_phase_t   ph_q;
   logic [W-1:0] cb_q, y0_q, cr_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ph_q   <= PH_CB;
         cb_q   <= '0;
         y0_q   <= '0;
         cr_q   <= '0;
         luma_o <= '0;
         cb_o   <= '0;
         cr_o   <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (start_i) begin
            ph_q <= PH_CB;
         end else if (take_i) begin
            ph_q <= vtd_phase_t'(ph_q + 2'd1);
            unique case (ph_q)
               PH_CB: cb_q <= smp_i;
               PH_Y0: y0_q <= smp_i;
               PH_CR: begin
                  cr_q   <= smp_i;
                  luma_o <= y0_q;
                  cb_o   <= cb_q;
                  cr_o   <= smp_i;
                  vld_o  <= 1'b1;
               end
               PH_Y1: begin
                  luma_o <= smp_i;
                  cb_o   <= cb_q;
                  cr_o   <= cr_q;
                  vld_o  <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/vtd_trs_decoder.sv
module vtd_trs_decoder #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] smp_i,
   output logic         fld_o,
   output logic         vblk_o,
   output logic         hblk_o,
   output logic         code_err_o,
   output logic         even_sof_o,
   output logic         odd_sof_o,
   output logic [W-1:0] luma_o,
   output logic [W-1:0] cb_o,
   output logic [W-1:0] cr_o,
   output logic         pix_vld_o
);
   import vtd_pkg::*;

   generate
      if (W < CODE_W || W > 16) begin : g_bad_width
         $error("vtd_trs_decoder: sample width W must lie in 8..16");
      end
   endgenerate

   logic       code_hit, ones, good, is_even, is_odd;
   vtd_flags_t cflags, flags_q;
   logic       locked_q, act_q, err_q, even_q, odd_q;
   logic       start, take;

   vtd_preamble #(.W(W)) u_pre (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_i      (smp_i),
      .code_hit_o (code_hit),
      .ones_o     (ones)
   );

   vtd_code_check #(.W(W)) u_chk_code (
      .smp_i     (smp_i),
      .good_o    (good),
      .flags_o   (cflags),
      .is_even_o (is_even),
      .is_odd_o  (is_odd)
   );

   assign start = code_hit && good;
   assign take  = act_q && !code_hit && !ones;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         locked_q <= 1'b0;
         flags_q  <= '0;
         act_q    <= 1'b0;
         err_q    <= 1'b0;
         even_q   <= 1'b0;
         odd_q    <= 1'b0;
      end else begin
         err_q  <= 1'b0;
         even_q <= 1'b0;
         odd_q  <= 1'b0;
         if (code_hit) begin
            if (good) begin
               locked_q <= 1'b1;
               flags_q  <= cflags;
               act_q    <= !cflags.v && !cflags.h;
               even_q   <= is_even;
               odd_q    <= is_odd;
            end else if (locked_q) begin
               err_q <= 1'b1;
            end
         end else if (act_q && ones) begin
            act_q <= 1'b0;
         end
      end
   end

   vtd_pixel_pair #(.W(W)) u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .take_i  (take),
      .smp_i   (smp_i),
      .luma_o  (luma_o),
      .cb_o    (cb_o),
      .cr_o    (cr_o),
      .vld_o   (pix_vld_o)
   );

   assign fld_o      = flags_q.f;
   assign vblk_o     = flags_q.v;
   assign hblk_o     = flags_q.h;
   assign code_err_o = err_q;
   assign even_sof_o = even_q;
   assign odd_sof_o  = odd_q;

endmodule

// File: rtl/vtd_trs_decoder_chk.sv
module vtd_trs_decoder_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [W-1:0] smp_i,
   input logic         fld_o,
   input logic         vblk_o,
   input logic         hblk_o,
   input logic         code_err_o,
   input logic         even_sof_o,
   input logic         odd_sof_o,
   input logic [W-1:0] luma_o,
   input logic [W-1:0] cb_o,
   input logic [W-1:0] cr_o,
   input logic         pix_vld_o
);

   AST_SOF_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({even_sof_o, odd_sof_o, code_err_o}) <= 1); // R6

   AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_err_o |-> $stable({fld_o, vblk_o, hblk_o})); // R4

   AST_EVEN_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      even_sof_o |-> (!fld_o && !vblk_o && !hblk_o)); // R6

   AST_ODD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      odd_sof_o |-> (fld_o && !vblk_o && !hblk_o)); // R6

   AST_PIX_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_vld_o |-> (!vblk_o && !hblk_o)); // R9

   AST_NO_PIX_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (even_sof_o || odd_sof_o) |=> !pix_vld_o); // R8

   AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pix_vld_o |-> $stable({luma_o, cb_o, cr_o})); // R10

   AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_err_o |=> !code_err_o); // R4

endmodule

bind vtd_trs_decoder vtd_trs_decoder_chk #(.W(W)) u_vtd_chk (.*);

// File: tb/vtd_trs_decoder_test.sv
module vtd_trs_decoder_test;

   localparam int W = 8;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         rst_ni = 1'b0;
   logic [W-1:0] smp = '0;

   logic         fld, vblk, hblk, cerr, esof, osof, vld;
   logic [W-1:0] luma, cb, cr;

   always #4 clk = ~clk;

   vtd_trs_decoder #(.W(W)) uut (
      .clk_i(clk), .rst_ni(rst_ni), .smp_i(smp),
      .fld_o(fld), .vblk_o(vblk), .hblk_o(hblk), .code_err_o(cerr),
      .even_sof_o(esof), .odd_sof_o(osof),
      .luma_o(luma), .cb_o(cb), .cr_o(cr), .pix_vld_o(vld)
   );

   // behavioural reference
   int hist[$];
   int m_lock, m_f, m_v, m_h, m_err, m_even, m_odd, m_vld, m_act, m_ph;
   int m_y, m_cb, m_cr, s_cb, s_y0, s_cr;
   int vectors = 0;
   int fails = 0;

   always @(posedge clk) begin
      int x, code;
      bit pre, ok;
      x = int'(smp);
      if (!rst_ni) begin
         hist.delete();
         m_lock = 0; m_f = 0; m_v = 0; m_h = 0; m_err = 0; m_even = 0; m_odd = 0;
         m_vld = 0; m_act = 0; m_ph = 0; m_y = 0; m_cb = 0; m_cr = 0;
         s_cb = 0; s_y0 = 0; s_cr = 0;
      end else begin
         m_err = 0; m_even = 0; m_odd = 0; m_vld = 0;
         pre = (hist.size() == 3) && (hist[0] == int'(ONES)) && (hist[1] == 0) && (hist[2] == 0);
         if (pre) begin
            code = x >> (W - 8);
            ok = code[7] && (code[3] == (code[5] ^ code[4])) && (code[2] == (code[6] ^ code[4]))
                 && (code[1] == (code[6] ^ code[5])) && (code[0] == (code[6] ^ code[5] ^ code[4]));
            if (ok) begin
               m_lock = 1; m_f = code[6]; m_v = code[5]; m_h = code[4];
               m_act = (m_v == 0 && m_h == 0);
               m_ph = 0;
               m_even = (code == 'h80);
               m_odd = (code == 'hC7);
            end else if (m_lock != 0) begin
               m_err = 1;
            end
         end else if (m_act != 0) begin
            if (x == int'(ONES)) m_act = 0;
            else begin
               case (m_ph)
                  0: s_cb = x;
                  1: s_y0 = x;
                  2: begin s_cr = x; m_y = s_y0; m_cb = s_cb; m_cr = x; m_vld = 1; end
                  default: begin m_y = x; m_cb = s_cb; m_cr = s_cr; m_vld = 1; end
               endcase
               m_ph = (m_ph + 1) % 4;
            end
         end
         hist.push_back(x);
         if (hist.size() > 3) void'(hist.pop_front());
      end
   end

   task automatic cmp1(input string req, input string nm, input int a, input int e);
      if (a != e) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, a, e, $time);
      end
   endtask

   task automatic compare(input string req);
      vectors++;
      cmp1(req, "fld", int'(fld), m_f);
      cmp1(req, "vblk", int'(vblk), m_v);
      cmp1(req, "hblk", int'(hblk), m_h);
      cmp1(req, "code_err", int'(cerr), m_err);
      cmp1(req, "even_sof", int'(esof), m_even);
      cmp1(req, "odd_sof", int'(osof), m_odd);
      cmp1(req, "pix_vld", int'(vld), m_vld);
      cmp1(req, "luma", int'(luma), m_y);
      cmp1(req, "cb", int'(cb), m_cb);
      cmp1(req, "cr", int'(cr), m_cr);
   endtask

   task automatic put(input int v, input string req);
      @(negedge clk);
      compare(req);
      smp = v[W-1:0];
   endtask

   task automatic preamble(input string req);
      put(int'(ONES), req); put(0, req); put(0, req);
   endtask

   task automatic samples(input int n, input string req);
      for (int i = 0; i < n; i++) put($urandom_range(1, 254), req);
   endtask

   function automatic int mk(input int f, input int v, input int h);
      return 128 + f * 64 + v * 32 + h * 16 + (v ^ h) * 8 + (f ^ h) * 4 + (f ^ v) * 2 + (f ^ v ^ h);
   endfunction

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      rst_ni = 1'b0;
      repeat (4) put(0, "R1");
      rst_ni = 1'b1;
      put(0, "R1");
      // R5: bad code and data before lock
      preamble("R5"); put('h81, "R5"); samples(6, "R5");
      // R2: code without leading all-ones, and broken preambles
      put(0, "R2"); put(0, "R2"); put('h80, "R2"); samples(4, "R2");
      put(int'(ONES), "R2"); put(0, "R2"); put(1, "R2"); put('hC7, "R2"); samples(4, "R2");
      // R3: every flag combination
      for (int k = 0; k < 8; k++) begin
         preamble("R3"); put(mk(k / 4, (k / 2) % 2, k % 2), "R3"); samples(4, "R3");
         put(int'(ONES), "R3");
      end
      // R9: blanking line produces no pixels
      preamble("R9"); put(mk(0, 1, 0), "R9"); samples(8, "R9");
      // R6 + R7: even field start and active line
      preamble("R6"); put('h80, "R6"); samples(8, "R7");
      preamble("R9"); put(mk(0, 0, 1), "R9"); samples(3, "R9");
      // R4: corrupted protection and cleared top bit
      preamble("R4"); put('h81, "R4"); samples(2, "R4");
      preamble("R4"); put('h00, "R4"); samples(2, "R4");
      preamble("R4"); put(mk(1, 1, 0) ^ 2, "R4"); put(5, "R4");
      // R6 + R8: odd start, partial line, phase restart
      preamble("R6"); put('hC7, "R6"); samples(6, "R8");
      preamble("R8"); put('hC7, "R8"); samples(8, "R8");
      preamble("R8"); put(mk(1, 0, 1), "R8"); samples(2, "R8");
      // R10: random lines with random codes and occasional corruption
      for (int ln = 0; ln < 300; ln++) begin
         int f, v, h, c;
         f = $urandom_range(0, 1); v = $urandom_range(0, 1); h = $urandom_range(0, 1);
         c = mk(f, v, h);
         if ($urandom_range(0, 7) == 0) c = c ^ (1 << $urandom_range(0, 7));
         preamble("R10"); put(c, "R10");
         samples($urandom_range(0, 24), "R10");
         if ($urandom_range(0, 3) == 0) put($urandom_range(0, 255), "R10");
      end
      put(0, "R10");
      put(0, "R10");
      finish_run();
   end

endmodule